// File: doc/BRIEF.md
# Status Byte and Service Request Logic

This block holds the eight-bit status byte of an instrument bus interface. Six summary lines come from the event registers and output queues elsewhere in the device and are mirrored into the byte one cycle later. None of these bits is latched. A programmable enable mask chooses which summary lines may raise a service request. From the masked summary lines the block forms a live master summary bit. It also keeps a latched request-for-service flag, and that flag drives the service-request line.

Bit 6 of the byte changes meaning with the kind of read. A query-style read (`poll_rd_i` low) shows the live master summary in bit 6 and has no side effects. A serial-poll read (`poll_rd_i` high for one cycle) shows the latched request flag in bit 6 and then clears that flag. A clear input, like power-on reset, empties the byte and the request flag. It leaves the enable mask as it is.

Top module: `stb_srq_core`

## Requirements
- R1: Bits 0, 2, 3, 4, 5 and 7 of `rd_data_o` show the matching bits of `sum_i` from the previous cycle. They do not latch, so a bit that drops at the input reads 0 one cycle later.
- R2: Bit 1 of `rd_data_o` always reads 0. Bits 1 and 6 of `sum_i` have no effect on any output.
- R3: While `poll_rd_i` is low, bit 6 of `rd_data_o` equals the OR, over bits 0, 2, 3, 4, 5 and 7, of (status bit AND enable bit). An enable bit of 0 keeps its status bit from setting bit 6.
- R4: Bit 6 of the enable mask is always stored as 0, and `en_rdata_o[6]` reads 0 whatever value is written.
- R5: A cycle with `en_we_i` high loads the whole mask from `en_wdata_i`, which sets or clears each bit. `en_rdata_o` shows the stored mask from the next cycle on. Reset clears the mask.
- R6: A rising edge of the master summary bit sets the request flag on the following clock edge. `srq_o` is high (active-high default) while the flag is set.
- R7: Once set, the request flag stays set without a serial poll, even after the master summary bit falls. It does not set again until the master summary bit has fallen and risen once more.
- R8: During a cycle with `poll_rd_i` high, bit 6 of `rd_data_o` shows the request flag. The flag is clear from the next cycle on unless R10 applies.
- R9: Query-style reads clear no bit of the status byte, no request flag and no mask bit.
- R10: If a serial poll falls in the same cycle as a new rising edge of the master summary bit, the poll returns the old flag value and the flag is set afterwards.
- R11: A cycle with `clear_i` high makes the whole status byte and the request flag read 0 in the next cycle and keeps the mask. Summary lines that are still active reappear one cycle later, and a request may then be raised again.
- R12: While reset is held, `rd_data_o`, `en_rdata_o` and `srq_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Clear-status strobe |
| sum_i | input | 8 | Summary lines; bits 1 and 6 are ignored |
| en_we_i | input | 1 | Enable-mask write strobe |
| en_wdata_i | input | 8 | New enable-mask value |
| en_rdata_o | output | 8 | Stored enable mask |
| poll_rd_i | input | 1 | Serial-poll read strobe; low selects the query view |
| rd_data_o | output | 8 | Status byte in the selected view |
| srq_o | output | 1 | Service-request line |

## Verification
Summary patterns with a single line, several lines and only the reserved lines are run with the mask fully open, fully closed and partly open. These show whether bit 6 truly follows the masked OR, or instead follows a plain OR or ignores the mask. Sequences that drop MSS while the flag is held, re-raise it without a poll, and poll on the very cycle of a new rising edge separate a level-driven or poll-losing request flag from the correct edge-set latch. Repeated query reads and a clear with a still-active source check that no read has a hidden side effect and that cleared bits return.

// File: rtl/stb_pkg.sv
package stb_pkg;
   localparam int unsigned STB_W    = 8;
   localparam int unsigned MSS_POS  = 6;
   localparam int unsigned RSVD_POS = 1;
   // bits that carry summary lines (all except MSS and the reserved bit)
   localparam logic [STB_W-1:0] SUM_BITS =
      ~((STB_W'(1) << MSS_POS) | (STB_W'(1) << RSVD_POS));
   // bits that the enable mask can hold
   localparam logic [STB_W-1:0] EN_BITS = ~(STB_W'(1) << MSS_POS);
endpackage

// File: rtl/stb_sum_reg.sv
module stb_sum_reg #(
   parameter int unsigned W = 8,
   parameter logic [W-1:0] LIVE = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic unused_dead;
   assign unused_dead = ^(d_i & ~LIVE);

   for (genvar b = 0; b < W; b++) begin : g_bit
      if (LIVE[b]) begin : g_live
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     q <= 1'b0;
            else if (clr_i) q <= 1'b0;
            else            q <= d_i[b];
         end
         assign q_o[b] = q;
      end else begin : g_dead
         assign q_o[b] = 1'b0;
      end
   end
endmodule

// File: rtl/stb_en_reg.sv
module stb_en_reg #(
   parameter int unsigned W = 8,
   parameter logic [W-1:0] LIVE = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] q_o
);
   logic unused_dead;
   assign unused_dead = ^(wdata_i & ~LIVE);

   for (genvar b = 0; b < W; b++) begin : g_bit
      if (LIVE[b]) begin : g_live
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    q <= 1'b0;
            else if (we_i) q <= wdata_i[b];
         end
         assign q_o[b] = q;
      end else begin : g_dead
         assign q_o[b] = 1'b0;
      end
   end
endmodule

// File: rtl/stb_rqs_ctrl.sv
module stb_rqs_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic mss_i,
   input  logic poll_i,
   output logic rqs_o,
   output logic mss_prev_o
);
   logic rqs_q, prev_q, rise;

   assign rise = mss_i & ~prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rqs_q  <= 1'b0;
         prev_q <= 1'b0;
      end else if (clr_i) begin
         rqs_q  <= 1'b0;
         prev_q <= 1'b0;
      end else begin
         prev_q <= mss_i;
         // a new edge wins over a poll so the request is not lost
         if (rise)        rqs_q <= 1'b1;
         else if (poll_i) rqs_q <= 1'b0;
      end
   end

   assign rqs_o      = rqs_q;
   assign mss_prev_o = prev_q;
endmodule

// File: rtl/stb_srq_core.sv
module stb_srq_core #(
   parameter int unsigned STB_W       = stb_pkg::STB_W,
   parameter int unsigned MSS_POS     = stb_pkg::MSS_POS,
   parameter int unsigned RSVD_POS    = stb_pkg::RSVD_POS,
   parameter bit          SRQ_ACT_LOW = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic [STB_W-1:0] sum_i,
   input  logic             en_we_i,
   input  logic [STB_W-1:0] en_wdata_i,
   output logic [STB_W-1:0] en_rdata_o,
   input  logic             poll_rd_i,
   output logic [STB_W-1:0] rd_data_o,
   output logic             srq_o
);
   localparam logic [STB_W-1:0] MSS_ONE  = STB_W'(1) << MSS_POS;
   localparam logic [STB_W-1:0] RSVD_ONE = STB_W'(1) << RSVD_POS;
   localparam logic [STB_W-1:0] SUM_BITS = ~(MSS_ONE | RSVD_ONE);
   localparam logic [STB_W-1:0] EN_BITS  = ~MSS_ONE;

   if (STB_W != 8) begin : g_bad_width
      $error("stb_srq_core: STB_W must be 8");
   end
   if (MSS_POS >= STB_W || RSVD_POS >= STB_W) begin : g_bad_pos
      $error("stb_srq_core: bit position out of range");
   end
   if (MSS_POS == RSVD_POS) begin : g_bad_overlap
      $error("stb_srq_core: MSS and reserved bits overlap");
   end

   logic [STB_W-1:0] stat_q, en_q, masked;
   logic             mss_w, rqs_q, mss_prev;

   stb_sum_reg #(.W(STB_W), .LIVE(SUM_BITS)) u_sum (
      .clk(clk), .rst_n(rst_n), .clr_i(clear_i), .d_i(sum_i), .q_o(stat_q)
   );

   stb_en_reg #(.W(STB_W), .LIVE(EN_BITS)) u_en (
      .clk(clk), .rst_n(rst_n), .we_i(en_we_i), .wdata_i(en_wdata_i), .q_o(en_q)
   );

   assign masked = stat_q & en_q & SUM_BITS;
   assign mss_w  = |masked;

   stb_rqs_ctrl u_rqs (
      .clk(clk), .rst_n(rst_n), .clr_i(clear_i), .mss_i(mss_w),
      .poll_i(poll_rd_i), .rqs_o(rqs_q), .mss_prev_o(mss_prev)
   );

   for (genvar b = 0; b < STB_W; b++) begin : g_rd
      if (b == MSS_POS) begin : g_b6
         assign rd_data_o[b] = poll_rd_i ? rqs_q : mss_w;
      end else begin : g_other
         assign rd_data_o[b] = stat_q[b];
      end
   end

   assign en_rdata_o = en_q;

   if (SRQ_ACT_LOW) begin : g_srq_low
      assign srq_o = ~rqs_q;
   end else begin : g_srq_high
      assign srq_o = rqs_q;
   end
endmodule

// File: rtl/stb_srq_chk.sv
module stb_srq_chk #(
   parameter bit SRQ_ACT_LOW = 1'b0
) (
   input logic       clk,
   input logic       rst_n,
   input logic       clear_i,
   input logic [7:0] sum_i,
   input logic       en_we_i,
   input logic [7:0] en_wdata_i,
   input logic [7:0] en_rdata_o,
   input logic       poll_rd_i,
   input logic [7:0] rd_data_o,
   input logic       srq_o,
   input logic       mss_w,
   input logic       rqs_q
);
   logic srq_act;
   assign srq_act = SRQ_ACT_LOW ? ~srq_o : srq_o;

   p_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !clear_i |=> ((rd_data_o & 8'hBD) == ($past(sum_i) & 8'hBD)));

   p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data_o[1] == 1'b0);

   p_mask6_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      en_rdata_o[6] == 1'b0);

   p_mask_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      en_we_i |=> (en_rdata_o == ($past(en_wdata_i) & 8'hBF)));

   p_rise_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(mss_w) && !clear_i) |=> srq_act);

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rqs_q && !poll_rd_i && !clear_i) |=> rqs_q);

   p_poll_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (poll_rd_i && !mss_w) |=> !srq_act);

   p_query_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!poll_rd_i && !clear_i && !en_we_i) |=> $stable(en_rdata_o));

   p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (rd_data_o == 8'h00 && !srq_act));
endmodule

bind stb_srq_core stb_srq_chk #(.SRQ_ACT_LOW(SRQ_ACT_LOW)) u_chk (
   .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .sum_i(sum_i),
   .en_we_i(en_we_i), .en_wdata_i(en_wdata_i), .en_rdata_o(en_rdata_o),
   .poll_rd_i(poll_rd_i), .rd_data_o(rd_data_o), .srq_o(srq_o),
   .mss_w(mss_w), .rqs_q(rqs_q)
);

// File: tb/sim_stb_srq_core.sv
module sim_stb_srq_core;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       clear_i = 1'b0;
   logic [7:0] sum_i = '0;
   logic       en_we_i = 1'b0;
   logic [7:0] en_wdata_i = '0;
   logic       poll_rd_i = 1'b0;
   logic [7:0] en_rdata_o, rd_data_o;
   logic       srq_o;

   always #2.5 clk = ~clk;   // 200 MHz

   stb_srq_core u0 (
      .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .sum_i(sum_i),
      .en_we_i(en_we_i), .en_wdata_i(en_wdata_i), .en_rdata_o(en_rdata_o),
      .poll_rd_i(poll_rd_i), .rd_data_o(rd_data_o), .srq_o(srq_o)
   );

   typedef struct {
      int         sel;   // 0 status byte, 1 mask, 2 srq line
      logic [7:0] exp;
      string      req;
   } item_t;

   item_t sb[$];
   event  mon_ev;
   int    n_chk = 0, n_err = 0;
   bit    done = 1'b0;

   // requirement-level model state
   logic [7:0] m_stat = '0, m_en = '0;
   logic       m_rqs = 1'b0, m_prev = 1'b0;

   // monitor: pops expected items and compares with the ports
   initial forever begin
      @(mon_ev);
      while (sb.size() > 0) begin
         item_t it;
         logic [7:0] act;
         it = sb.pop_front();
         case (it.sel)
            0: act = rd_data_o;
            1: act = en_rdata_o;
            default: act = {7'b0, srq_o};
         endcase
         n_chk++;
         if (act !== it.exp) begin
            n_err++;
            $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
         end
      end
   end

   task automatic push3(input string req, input logic [7:0] v, input logic [7:0] e, input logic s);
      sb.push_back('{0, v, req});
      sb.push_back('{1, e, req});
      sb.push_back('{2, {7'b0, s}, req});
      -> mon_ev;
   endtask

   task automatic tick(input logic [7:0] s, input logic we, input logic [7:0] wd,
                       input logic poll, input logic clr, input string req);
      logic [7:0] view;
      logic       mss, rise;
      @(negedge clk);
      sum_i = s; en_we_i = we; en_wdata_i = wd; poll_rd_i = poll; clear_i = clr;
      #1;
      mss  = |(m_stat & m_en & 8'hBD);
      view = m_stat;
      view[6] = poll ? m_rqs : mss;
      push3(req, view, m_en, m_rqs);
      rise = mss & ~m_prev;
      if (clr) begin
         m_rqs = 1'b0; m_prev = 1'b0; m_stat = '0;
      end else begin
         if (rise)      m_rqs = 1'b1;
         else if (poll) m_rqs = 1'b0;
         m_prev = mss;
         m_stat = s & 8'hBD;
      end
      if (we) m_en = wd & 8'hBF;
   endtask

   initial begin
      #400000;
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      push3("R12", 8'h00, 8'h00, 1'b0);          // reset state
      rst_n = 1'b1;
      tick(8'h00, 1, 8'hFF, 0, 0, "R5");         // write full mask
      tick(8'h00, 0, 8'h00, 0, 0, "R4");         // readback shows 0xBF
      tick(8'h42, 0, 8'h00, 0, 0, "R2");         // reserved/MSS inputs only
      tick(8'h42, 0, 8'h00, 0, 0, "R2");
      tick(8'h01, 0, 8'h00, 0, 0, "R1");
      tick(8'h01, 0, 8'h00, 0, 0, "R3");         // MSS live
      tick(8'h01, 0, 8'h00, 0, 0, "R6");         // request raised
      tick(8'h00, 0, 8'h00, 0, 0, "R1");         // source drops
      tick(8'h00, 0, 8'h00, 0, 0, "R7");         // flag held, MSS low
      tick(8'h00, 0, 8'h00, 0, 0, "R9");
      tick(8'h00, 0, 8'h00, 1, 0, "R8");         // poll returns flag
      tick(8'h00, 0, 8'h00, 0, 0, "R8");
      // mask closed: summary bits cannot raise MSS
      tick(8'hBD, 1, 8'h00, 0, 0, "R3");
      tick(8'hBD, 0, 8'h00, 0, 0, "R3");
      tick(8'hBD, 0, 8'h00, 0, 0, "R3");
      // partial mask: only bit 4 enabled
      tick(8'h20, 1, 8'h10, 0, 0, "R3");
      tick(8'h20, 0, 8'h00, 0, 0, "R3");
      tick(8'h30, 0, 8'h00, 0, 0, "R3");
      tick(8'h30, 0, 8'h00, 0, 0, "R6");
      tick(8'h30, 0, 8'h00, 0, 0, "R9");
      tick(8'h30, 0, 8'h00, 0, 0, "R9");         // query reads clear nothing
      tick(8'h30, 0, 8'h00, 1, 0, "R8");         // poll while MSS stays high
      tick(8'h30, 0, 8'h00, 0, 0, "R7");         // no re-set without new edge
      tick(8'h30, 0, 8'h00, 0, 0, "R7");
      // fall then rise again, no poll: flag re-set
      tick(8'h20, 0, 8'h00, 0, 0, "R7");
      tick(8'h30, 0, 8'h00, 0, 0, "R7");
      tick(8'h30, 0, 8'h00, 0, 0, "R7");
      tick(8'h30, 0, 8'h00, 0, 0, "R6");
      // flag set, MSS falls, then poll on the cycle of a new rising edge
      tick(8'h00, 0, 8'h00, 0, 0, "R10");
      tick(8'h10, 0, 8'h00, 0, 0, "R10");
      tick(8'h10, 0, 8'h00, 1, 0, "R10");        // poll + rise together
      tick(8'h10, 0, 8'h00, 0, 0, "R10");        // flag still set
      tick(8'h10, 0, 8'h00, 1, 0, "R8");
      tick(8'h10, 0, 8'h00, 0, 0, "R8");
      // clear with source still active
      tick(8'h91, 1, 8'h81, 0, 0, "R5");
      tick(8'h91, 0, 8'h00, 0, 0, "R11");
      tick(8'h91, 0, 8'h00, 0, 0, "R11");
      tick(8'h91, 0, 8'h00, 0, 1, "R11");
      tick(8'h91, 0, 8'h00, 0, 0, "R11");        // all zero, mask kept
      tick(8'h91, 0, 8'h00, 0, 0, "R11");        // sources back
      tick(8'h00, 0, 8'h00, 0, 0, "R11");        // request raised again
      tick(8'h00, 0, 8'h00, 0, 0, "R1");
      #1;
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule